// File: doc/BRIEF.md
# Host and Local Processor Interrupt Handshake Registers

This block holds the few registers that let a bus-attached coprocessor and its host signal each other. The local processor raises an interrupt toward the host by setting a request bit. That interrupt is level-held until one side clears it. The host can mask the line without losing the pending flag, and it can read the flag back. In the other direction, the host rings a doorbell that becomes a single-cycle interrupt pulse on the local side, but only while the local enable bit is set.

Two plain register ports are provided. Each port has a write strobe, a word address and write data, and returns read data combinationally for the address it presents. Bus protocol and address decoding above the word address are handled elsewhere.

The register map is:
- Word 0 is the status register, visible on the host port.
- Word 1 is the doorbell register, visible on the host port.
- Word 2 is the source control register, visible on both ports.
- Word 3 is the local enable register, visible on the local port.

Top module: `hostdsp_irq_regs`

## Requirements
- R1: A synchronous active-high reset sets the pending flag to 0, the mask to 1 and the local enable to 0. Both interrupt outputs then read 0, and a host read of word 0 returns 0x4.
- R2: A local-port write to word 2 with bit 3 set marks the host interrupt pending at the next clock edge. Host-port writes to bit 3 are ignored. While the interrupt is pending and unmasked, `host_irq` stays high on every cycle until it is cleared.
- R3: A write to word 2 with bit 4 set clears the pending flag from either port, and `host_irq` is low on the following cycle.
- R4: Bit 2 of word 0 is the mask. It is writable by the host. While it is 1, `host_irq` is 0 even though the pending flag is kept.
- R5: Bit 0 of word 0 reads 1 while the interrupt is pending and 0 otherwise, independent of the mask.
- R6: A host write to word 0 with bit 0 set clears the pending flag. A write with bit 0 equal to 0 leaves the pending flag unchanged.
- R7: When a request and any clear land on the same clock edge, the clear wins and the flag ends at 0.
- R8: A host write to word 1 with bit 0 set, while bit 0 of local word 3 is 1, produces `local_irq` high for exactly the next cycle.
- R9: A doorbell written while the local enable is 0 is dropped. Setting the enable afterwards produces no pulse.
- R10: The request, clear and doorbell bits always read back as 0. Bit 0 of word 3 on the local port reads back the enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| h_we | input | 1 | Host write strobe |
| h_addr | input | AW | Host word address |
| h_wdata | input | DW | Host write data |
| h_rdata | output | DW | Host read data for h_addr |
| l_we | input | 1 | Local write strobe |
| l_addr | input | AW | Local word address |
| l_wdata | input | DW | Local write data |
| l_rdata | output | DW | Local read data for l_addr |
| host_irq | output | 1 | Level interrupt toward the host |
| local_irq | output | 1 | One-cycle doorbell interrupt toward the local processor |

## Verification
The bench targets a request and a clear landing on the same edge. A design with the wrong priority would leave `host_irq` stuck high after the driver believes it cleared the line.

It writes 0 to the source bit while an interrupt is pending. A design that treated that bit as plain read/write would silently drop the interrupt.

It rings the doorbell while the local enable is off and then turns the enable on. A design that latched the doorbell would fire a stale pulse.

It also holds the unmasked line across idle cycles, to catch a design that emits a pulse instead of a level.

// File: rtl/hostdsp_irq_regs.sv
module hostdsp_irq_regs #(
  parameter int DW = 32,
  parameter int AW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          h_we,
  input  logic [AW-1:0] h_addr,
  input  logic [DW-1:0] h_wdata,
  output logic [DW-1:0] h_rdata,
  input  logic          l_we,
  input  logic [AW-1:0] l_addr,
  input  logic [DW-1:0] l_wdata,
  output logic [DW-1:0] l_rdata,
  output logic          host_irq,
  output logic          local_irq
);
  localparam logic [AW-1:0] A_STAT = AW'(0);
  localparam logic [AW-1:0] A_BELL = AW'(1);
  localparam logic [AW-1:0] A_CTRL = AW'(2);
  localparam logic [AW-1:0] A_IEN  = AW'(3);
  localparam int B_SRC = 0;
  localparam int B_MASK = 2;
  localparam int B_REQ = 3;
  localparam int B_CLR = 4;
  localparam int B_BELL = 0;
  localparam int B_IEN = 0;

  logic pend_q, mask_q, ien_q, lirq_q;
  logic h_stat_wr, h_ctrl_wr, l_ctrl_wr;
  logic set_req, clr_any, bell;

  assign h_stat_wr = h_we && (h_addr == A_STAT);
  assign h_ctrl_wr = h_we && (h_addr == A_CTRL);
  assign l_ctrl_wr = l_we && (l_addr == A_CTRL);

  assign set_req = l_ctrl_wr && l_wdata[B_REQ];
  assign clr_any = (h_stat_wr && h_wdata[B_SRC])
                || (h_ctrl_wr && h_wdata[B_CLR])
                || (l_ctrl_wr && l_wdata[B_CLR]);
  assign bell    = h_we && (h_addr == A_BELL) && h_wdata[B_BELL];

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
      mask_q <= 1'b1;
      ien_q  <= 1'b0;
      lirq_q <= 1'b0;
    end else begin
      if (clr_any)      pend_q <= 1'b0;
      else if (set_req) pend_q <= 1'b1;
      if (h_stat_wr) mask_q <= h_wdata[B_MASK];
      if (l_we && (l_addr == A_IEN)) ien_q <= l_wdata[B_IEN];
      lirq_q <= bell && ien_q;
    end
  end

  assign host_irq  = pend_q && !mask_q;
  assign local_irq = lirq_q;

  always_comb begin
    h_rdata = '0;
    if (h_addr == A_STAT) begin
      h_rdata[B_SRC]  = pend_q;
      h_rdata[B_MASK] = mask_q;
    end
  end

  always_comb begin
    l_rdata = '0;
    if (l_addr == A_IEN) l_rdata[B_IEN] = ien_q;
  end

  assert_level_hold_R2: assert property (@(posedge clk) disable iff (rst)
    host_irq && !clr_any && !(h_stat_wr && h_wdata[B_MASK]) |=> host_irq);

  assert_clear_drops_R3: assert property (@(posedge clk) disable iff (rst)
    clr_any |=> !host_irq && (h_addr != A_STAT || !h_rdata[B_SRC]));

  assert_mask_blocks_R4: assert property (@(posedge clk) disable iff (rst)
    (h_rdata[B_MASK] || h_addr != A_STAT) && mask_q && !h_stat_wr |=> !host_irq);

  assert_src_w0_keeps_R6: assert property (@(posedge clk) disable iff (rst)
    pend_q && !clr_any |=> pend_q);

  assert_clear_wins_R7: assert property (@(posedge clk) disable iff (rst)
    set_req && clr_any |=> !pend_q);

  assert_bell_gated_R9: assert property (@(posedge clk) disable iff (rst)
    !ien_q |=> !local_irq);

  assert_bell_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    local_irq |-> $past(bell));
endmodule

// File: tb/hostdsp_irq_regs_tb.sv
module hostdsp_irq_regs_tb;
  localparam int DW = 32;
  localparam int AW = 2;

  logic clk = 1'b0;
  logic rst;
  logic h_we, l_we;
  logic [AW-1:0] h_addr, l_addr;
  logic [DW-1:0] h_wdata, l_wdata, h_rdata, l_rdata;
  logic host_irq, local_irq;

  int total = 0;
  int bad = 0;
  bit done = 0;

  bit m_pend, m_mask, m_ien, m_lirq;

  always #10 clk = ~clk;

  hostdsp_irq_regs #(.DW(DW), .AW(AW)) u_dut (
    .clk(clk), .rst(rst),
    .h_we(h_we), .h_addr(h_addr), .h_wdata(h_wdata), .h_rdata(h_rdata),
    .l_we(l_we), .l_addr(l_addr), .l_wdata(l_wdata), .l_rdata(l_rdata),
    .host_irq(host_irq), .local_irq(local_irq));

  // Behavioural reference model, updated on every rising edge.
  always @(posedge clk) begin
    if (rst) begin
      m_pend <= 0;
      m_mask <= 1;
      m_ien  <= 0;
      m_lirq <= 0;
    end else begin
      bit clr;
      bit req;
      clr = (h_we && h_addr == 0 && h_wdata[0])
         || (h_we && h_addr == 2 && h_wdata[4])
         || (l_we && l_addr == 2 && l_wdata[4]);
      req = l_we && l_addr == 2 && l_wdata[3];
      if (clr)      m_pend <= 0;
      else if (req) m_pend <= 1;
      if (h_we && h_addr == 0) m_mask <= h_wdata[2];
      if (l_we && l_addr == 3) m_ien <= l_wdata[0];
      m_lirq <= h_we && h_addr == 1 && h_wdata[0] && m_ien;
    end
  end

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // Compare every output against the model on each falling edge.
  always @(negedge clk) begin
    if (!rst && !done) begin
      logic [DW-1:0] eh;
      logic [DW-1:0] el;
      eh = '0;
      el = '0;
      if (h_addr == 0) begin
        eh[0] = m_pend;
        eh[2] = m_mask;
      end
      if (l_addr == 3) el[0] = m_ien;
      chk("R2/R4 host_irq model", {31'b0, host_irq}, {31'b0, m_pend & ~m_mask});
      chk("R8/R9 local_irq model", {31'b0, local_irq}, {31'b0, m_lirq});
      chk("R5/R10 h_rdata model", h_rdata, eh);
      chk("R10 l_rdata model", l_rdata, el);
    end
  end

  task automatic hw(input int a, input int d);
    @(negedge clk); #1;
    h_we = 1; h_addr = AW'(a); h_wdata = DW'(d);
    @(negedge clk); #1;
    h_we = 0; h_addr = 0;
  endtask

  task automatic lw(input int a, input int d);
    @(negedge clk); #1;
    l_we = 1; l_addr = AW'(a); l_wdata = DW'(d);
    @(negedge clk); #1;
    l_we = 0; l_addr = 3;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
    #1;
  endtask

  initial begin
    h_we = 0; l_we = 0; h_addr = 0; l_addr = 3; h_wdata = 0; l_wdata = 0;
    rst = 1;
    idle(3);
    rst = 0;
    #1;
    chk("R1 status after reset", h_rdata, 32'h4);
    chk("R1 host_irq after reset", {31'b0, host_irq}, 32'h0);
    chk("R1 enable after reset", l_rdata, 32'h0);

    lw(2, 32'h8);
    chk("R4 masked line low", {31'b0, host_irq}, 32'h0);
    chk("R5 source reads pending", h_rdata, 32'h5);

    hw(0, 32'h0);
    chk("R6 write0 keeps pending", h_rdata, 32'h1);
    chk("R2 line asserted", {31'b0, host_irq}, 32'h1);
    idle(5);
    chk("R2 line still held", {31'b0, host_irq}, 32'h1);

    hw(0, 32'h1);
    chk("R6 w1c clears", h_rdata, 32'h0);
    chk("R3 line low after clear", {31'b0, host_irq}, 32'h0);

    hw(2, 32'h8);
    chk("R2 host request ignored", h_rdata, 32'h0);

    lw(2, 32'h8);
    lw(2, 32'h10);
    chk("R3 local clear", {31'b0, host_irq}, 32'h0);

    lw(2, 32'h8);
    hw(2, 32'h10);
    chk("R3 host clear", h_rdata, 32'h0);

    lw(2, 32'h18);
    chk("R7 same-write clear wins", {31'b0, host_irq}, 32'h0);

    @(negedge clk); #1;
    l_we = 1; l_addr = 2; l_wdata = 32'h8;
    h_we = 1; h_addr = 0; h_wdata = 32'h1;
    @(negedge clk); #1;
    l_we = 0; h_we = 0; l_addr = 3;
    chk("R7 cross-port clear wins", h_rdata, 32'h0);

    hw(1, 32'h1);
    chk("R9 bell dropped", {31'b0, local_irq}, 32'h0);
    lw(3, 32'h1);
    chk("R10 enable reads back", l_rdata, 32'h1);
    idle(2);
    chk("R9 no stale pulse", {31'b0, local_irq}, 32'h0);

    @(negedge clk); #1;
    h_we = 1; h_addr = 1; h_wdata = 32'h1;
    @(negedge clk); #1;
    h_we = 0; h_addr = 0;
    chk("R8 pulse present", {31'b0, local_irq}, 32'h1);
    @(negedge clk); #1;
    chk("R8 pulse one cycle", {31'b0, local_irq}, 32'h0);

    @(negedge clk); #1;
    h_addr = 1;
    #1;
    chk("R10 bell reads 0", h_rdata, 32'h0);
    h_addr = 2;
    #1;
    chk("R10 ctrl reads 0", h_rdata, 32'h0);
    h_addr = 0;
    idle(2);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #2_000_000;
    total++;
    bad++;
    $display("FAIL watchdog act=hung exp=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule